// File: doc/BRIEF.md
# Iterative AES-128 Block Decryptor

This core recovers one 128-bit plaintext block from one 128-bit ciphertext block using AES-128 with a key fixed at build time. The key is never supplied at run time. The only key material held in logic is the final round key of the forward schedule, given as a parameter. The earlier round keys are rebuilt one per clock by running the forward schedule's XOR chain backwards, so the core needs no key storage beyond one 128-bit register.

A block is presented on `data_i` together with a one-cycle `start_i` while the core is idle. The core first XORs the block with round key 10. It then runs one round per clock. Each of the nine full rounds does InvShiftRows, InvSubBytes, AddRoundKey and then InvMixColumns. The last round skips the column mix and adds round key 0. When the block is finished, `done_o` pulses and the plaintext is held on `data_o` until the next block completes.

Top module: `aes_inv_core`

## Requirements
- R1: During and after reset, and before any block has been accepted, `busy_o`, `done_o` and `data_o` are all zero.
- R2: A high `start_i` sampled on a rising edge while `busy_o` is low accepts `data_i`, and `busy_o` is high after that edge.
- R3: `done_o` is high for exactly one cycle, following the 10th rising edge after the accepting edge. `busy_o` falls on that same edge, and `done_o` is never high while `busy_o` is high.
- R4: With the default key parameter (final round key d014f9a8c9ee2589e13f0cc8b6630ca6), the plaintext on `data_o` is correct for every block. Byte 0 is bits 127:120 and bytes are taken column-major. Examples: 3ad77bb40d7a3660a89ecaf32466ef97 gives 6bc1bee22e409f96e93d7e117393172a; f5d3d58503b9699de785895a96fdbaaf gives ae2d8a571e03ac9c9eb76fac45af8e51; 43b1cd7f598ece23881b00e3ed030688 gives 30c81c46a35ce411e5fbc1191a0a52ef; 7b0c785e27e8ad3f8223207104725dd4 gives f69f2445df4f9b17ad2b417be66c3710.
- R5: A `start_i` that arrives while `busy_o` is high is ignored. It changes neither the result nor the completion cycle of the block in flight.
- R6: `data_o` changes only on the edge that raises `done_o`, and holds its value otherwise.
- R7: A new block may be started on the edge right after the one that raised `done_o`, giving back-to-back throughput of one block per 11 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request; accepted only when idle |
| data_i | input | 128 | Ciphertext block, byte 0 in bits 127:120 |
| busy_o | output | 1 | High while a block is in progress |
| done_o | output | 1 | One-cycle pulse when the plaintext is ready |
| data_o | output | 128 | Recovered plaintext, held until the next completion |

## Verification
Four known ciphertext blocks are decrypted. Their plaintexts share no structure, so a fault in any inverse stage, in the key-walk constant, or in the round count produces a wrong value. One block is followed at once by another, which shows that the round counter and key register are reloaded cleanly with no gap. A run with a second start request held during processing, carrying a different block, separates a core that ignores mid-flight requests from one that restarts or corrupts its state. Idle cycles after completion confirm that the result holds.

// File: rtl/aes_inv_pkg.sv
package aes_inv_pkg;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, aa;
    p  = 8'h00;
    aa = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ aa;
      aa = xtime(aa);
    end
    return p;
  endfunction

  // a^254 is the field inverse; 0 maps to 0
  function automatic logic [7:0] ginv(input logic [7:0] a);
    logic [7:0] r, sq;
    r  = 8'h01;
    sq = a;
    for (int i = 1; i < 8; i++) begin
      sq = gmul(sq, sq);
      r  = gmul(r, sq);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] x, input int n);
    return (x << n) | (x >> (8 - n));
  endfunction

  function automatic logic [7:0] sbox_fwd(input logic [7:0] x);
    logic [7:0] g;
    g = ginv(x);
    return g ^ rotl8(g, 1) ^ rotl8(g, 2) ^ rotl8(g, 3) ^ rotl8(g, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] sbox_inv(input logic [7:0] y);
    logic [7:0] t;
    t = rotl8(y, 1) ^ rotl8(y, 3) ^ rotl8(y, 6) ^ 8'h05;
    return ginv(t);
  endfunction

  // round constant for the key word of round idx (1..10); 0 for idx 0
  function automatic logic [7:0] rcon(input int idx);
    logic [7:0] r;
    r = 8'h01;
    for (int k = 1; k < 16; k++) begin
      if (k < idx) r = xtime(r);
    end
    return (idx == 0) ? 8'h00 : r;
  endfunction

endpackage

// File: rtl/aes_inv_key_step.sv
// Rebuilds round key i-1 from round key i.
module aes_inv_key_step
  import aes_inv_pkg::*;
(
  input  logic [127:0] key_i,
  input  logic [7:0]   rcon_i,
  output logic [127:0] key_o
);
  logic [31:0] w0, w1, w2, w3, p0, p1, p2, p3, rot, sub;

  assign {w0, w1, w2, w3} = key_i;
  assign p3  = w3 ^ w2;
  assign p2  = w2 ^ w1;
  assign p1  = w1 ^ w0;
  assign rot = {p3[23:0], p3[31:24]};

  for (genvar g = 0; g < 4; g++) begin : g_sub
    assign sub[8*g +: 8] = sbox_fwd(rot[8*g +: 8]);
  end

  assign p0    = w0 ^ sub ^ {rcon_i, 24'h0};
  assign key_o = {p0, p1, p2, p3};
endmodule

// File: rtl/aes_inv_round.sv
// One inverse round; last_i drops the column mix.
module aes_inv_round
  import aes_inv_pkg::*;
(
  input  logic [127:0] state_i,
  input  logic [127:0] rkey_i,
  input  logic         last_i,
  output logic [127:0] state_o
);
  logic [127:0] shifted, subbed, keyed, mixed;

  for (genvar b = 0; b < 16; b++) begin : g_byte
    localparam int ROW = b % 4;
    localparam int COL = b / 4;
    localparam int SRC = 4 * ((COL - ROW + 4) % 4) + ROW;
    assign shifted[127-8*b -: 8] = state_i[127-8*SRC -: 8];
    assign subbed[127-8*b -: 8]  = sbox_inv(shifted[127-8*b -: 8]);
  end

  assign keyed = subbed ^ rkey_i;

  for (genvar c = 0; c < 4; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      logic [7:0] a0, a1, a2, a3;
      assign a0 = keyed[127-8*(4*c+((r+0)%4)) -: 8];
      assign a1 = keyed[127-8*(4*c+((r+1)%4)) -: 8];
      assign a2 = keyed[127-8*(4*c+((r+2)%4)) -: 8];
      assign a3 = keyed[127-8*(4*c+((r+3)%4)) -: 8];
      assign mixed[127-8*(4*c+r) -: 8] =
        gmul(a0, 8'h0e) ^ gmul(a1, 8'h0b) ^ gmul(a2, 8'h0d) ^ gmul(a3, 8'h09);
    end
  end

  assign state_o = last_i ? keyed : mixed;
endmodule

// File: rtl/aes_inv_core.sv
module aes_inv_core
  import aes_inv_pkg::*;
#(
  parameter logic [127:0] LAST_RKEY = 128'hd014f9a8c9ee2589e13f0cc8b6630ca6,
  parameter int           NR        = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [127:0] data_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [127:0] data_o
);
  localparam int RW = $clog2(NR + 1);

  logic [127:0] state_q, key_q, out_q, step_in, step_out, round_out;
  logic [RW-1:0] rnd_q;
  logic busy_q, done_q, accept;
  logic [7:0] step_rc;

  assign accept  = start_i & ~busy_q;
  assign step_in = busy_q ? key_q : LAST_RKEY;
  assign step_rc = busy_q ? rcon(int'(rnd_q)) : rcon(NR);

  aes_inv_key_step u_key (
    .key_i  (step_in),
    .rcon_i (step_rc),
    .key_o  (step_out)
  );

  aes_inv_round u_round (
    .state_i (state_q),
    .rkey_i  (key_q),
    .last_i  (rnd_q == '0),
    .state_o (round_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      key_q   <= '0;
      out_q   <= '0;
      rnd_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state_q <= data_i ^ LAST_RKEY;
        key_q   <= step_out;
        rnd_q   <= RW'(NR - 1);
        busy_q  <= 1'b1;
      end else if (busy_q) begin
        state_q <= round_out;
        key_q   <= step_out;
        if (rnd_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          out_q  <= round_out;
        end else begin
          rnd_q <= rnd_q - 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign data_o = out_q;

  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R2
  AST_ROUND_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && rnd_q != '0) |=> (busy_q && rnd_q == $past(rnd_q) - 1'b1)); // R5
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R3
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(data_o)); // R6
endmodule

// File: tb/aes_inv_core_tb.sv
module aes_inv_core_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [127:0] data_i = '0;
  logic         busy_o, done_o;
  logic [127:0] data_o;

  int errors = 0;
  int checks = 0;

  localparam logic [127:0] C1 = 128'h3ad77bb40d7a3660a89ecaf32466ef97;
  localparam logic [127:0] P1 = 128'h6bc1bee22e409f96e93d7e117393172a;
  localparam logic [127:0] C2 = 128'hf5d3d58503b9699de785895a96fdbaaf;
  localparam logic [127:0] P2 = 128'hae2d8a571e03ac9c9eb76fac45af8e51;
  localparam logic [127:0] C3 = 128'h43b1cd7f598ece23881b00e3ed030688;
  localparam logic [127:0] P3 = 128'h30c81c46a35ce411e5fbc1191a0a52ef;
  localparam logic [127:0] C4 = 128'h7b0c785e27e8ad3f8223207104725dd4;
  localparam logic [127:0] P4 = 128'hf69f2445df4f9b17ad2b417be66c3710;

  always #5 clk_i = ~clk_i;

  aes_inv_core u_dut (
    .clk_i, .rst_ni, .start_i, .data_i, .busy_o, .done_o, .data_o
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // entered at a negedge; returns at the negedge after the completing edge
  task automatic t_block(input logic [127:0] ct, input logic [127:0] pt,
                         input bit poke_busy, input string req);
    start_i = 1'b1;
    data_i  = ct;
    @(negedge clk_i);
    chk(busy_o === 1'b1, "R2 busy after accept", {127'b0, busy_o}, 128'd1);
    if (poke_busy) data_i = ~ct;  // R5: start held while busy
    else start_i = 1'b0;
    for (int i = 1; i < 10; i++) begin
      @(negedge clk_i);
      if (i == 4) start_i = 1'b0;
      chk(done_o === 1'b0 && busy_o === 1'b1, "R3 no early done",
          {126'b0, busy_o, done_o}, 128'd2);
    end
    start_i = 1'b0;
    @(negedge clk_i);
    chk(done_o === 1'b1 && busy_o === 1'b0, "R3 done on 10th edge",
        {126'b0, busy_o, done_o}, 128'd1);
    chk(data_o === pt, req, data_o, pt);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk_i);
    chk(busy_o === 1'b0 && done_o === 1'b0, "R1 reset flags",
        {126'b0, busy_o, done_o}, 128'd0);
    chk(data_o === '0, "R1 reset data", data_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(busy_o === 1'b0 && data_o === '0, "R1 idle after reset", data_o, '0);
  endtask

  task automatic t_vectors;
    t_block(C1, P1, 1'b0, "R4 block 1");
    @(negedge clk_i);
    t_block(C2, P2, 1'b0, "R4 block 2");
    @(negedge clk_i);
    t_block(C3, P3, 1'b0, "R4 block 3");
  endtask

  task automatic t_back_to_back;
    t_block(C4, P4, 1'b0, "R4 block 4");
    t_block(C2, P2, 1'b0, "R7 back-to-back block");
  endtask

  task automatic t_hold;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk(done_o === 1'b0 && data_o === P2, "R6 output held", data_o, P2);
    end
  endtask

  task automatic t_ignore;
    t_block(C3, P3, 1'b1, "R5 start while busy ignored");
    @(negedge clk_i);
    chk(busy_o === 1'b0 && data_o === P3, "R5 idle, result kept", data_o, P3);
  endtask

  initial begin
    t_reset();
    t_vectors();
    t_back_to_back();
    t_hold();
    t_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule